// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital half of a dual-slope integrating converter. On a start pulse it first closes a discharge switch for a fixed number of cycles. It then lets the external integrator accumulate the unknown input for exactly 2^N clocks, where N is the code width. The end of that window is marked by the phase counter wrapping. At that point the block switches the integrator to the opposite-polarity reference. The same counter, cleared to zero, then measures how long the integrator takes to run back down to zero.

The comparator bit arrives asynchronously and is retimed by two flops. The count seen when the retimed bit rises is therefore two larger than the true number of reference cycles, and the block subtracts that offset before storing the code. The code sits in an output register separate from the running counter and is announced by a one-cycle strobe. If the comparator never trips within the measurable range, the block stores all ones and flags the result as over range.

The states are ST_IDLE, ST_RESET, ST_INTEG1, ST_INTEG2 and ST_DONE. The transitions are:
- ST_IDLE to ST_RESET on start.
- ST_RESET to ST_INTEG1 once the discharge count is exhausted.
- ST_INTEG1 to ST_INTEG2 on counter overflow.
- ST_INTEG2 to ST_DONE on a retimed comparator trip or when the count limit is reached.
- ST_DONE to ST_IDLE unconditionally.

Top module: `dslope_ctrl`

## Requirements
- R1: While reset is held and right after it is released, discharge_o, integ_en_o, sel_ref_o, valid_o, overrange_o and result_o are all 0.
- R2: A start_i pulse seen in idle drives discharge_o high for exactly DISCH_CYC consecutive cycles (default 4). integ_en_o stays low during that time.
- R3: After discharge, integ_en_o is high with sel_ref_o low (input selected) for exactly 2^CNT_W cycles (8 by default).
- R4: When the first phase ends, sel_ref_o goes to 1 (reference selected) while integ_en_o stays high. sel_ref_o is never high without integ_en_o.
- R5: The stored code equals the number of reference-phase clocks needed for the integrator to return to zero. The two-cycle retiming delay is removed. valid_o rises DISCH_CYC+11+code cycles after the clock edge that samples start.
- R6: When the retimed comparator is still low at a raw count of 2^CNT_W+1, result_o is all ones and overrange_o is 1. A code of exactly 2^CNT_W-1 is reported with overrange_o at 0.
- R7: valid_o is high for exactly one cycle per conversion and the block then returns to idle. result_o and overrange_o hold their value until the next conversion completes.
- R8: A start_i pulse during a conversion is ignored: the latency is unchanged and no extra conversion follows.
- R9: If the integrator is already at zero when the reference phase begins, the code is 0. valid_o then rises DISCH_CYC+9 cycles after start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (honoured only in idle) |
| cmp_zero_i | input | 1 | Asynchronous comparator: 1 when the integrator is at or below zero |
| discharge_o | output | 1 | Close the integrator reset switch |
| integ_en_o | output | 1 | Integrator running |
| sel_ref_o | output | 1 | Integrator source: 0 input, 1 reference |
| result_o | output | CNT_W | Stored conversion code |
| valid_o | output | 1 | One-cycle strobe with each new code |
| overrange_o | output | 1 | Stored code is saturated |

## Verification
The edge that samples start is counted as cycle zero. Discharge takes cycles 0 to DISCH_CYC-1 and the input phase takes the next eight. For a nonzero code the strobe is due in cycle DISCH_CYC+11+code, for code zero in DISCH_CYC+9, and for an over-range result in DISCH_CYC+18. The bench models the integrator as an accumulator updated on each edge from the block's own select and enable outputs. It samples every output on the falling edge and counts cycles from the start edge. The measured latency, discharge length and phase length are then compared with those formulas, and the code is compared with the rounded-up quotient of charge over reference step.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_INTEG1 = 3'd2,
        ST_INTEG2 = 3'd3,
        ST_DONE   = 3'd4
    } dsc_state_e;
endpackage

// File: rtl/dslope_sync.sv
// Multi-flop retimer for the asynchronous comparator bit.
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dslope_counter.sv
// Phase counter shared by both integration phases; clear wins over count.
module dslope_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (en_i)  cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/dslope_result.sv
// Output code register: removes the retiming offset or saturates.
module dslope_result #(
    parameter int CNT_W    = 3,
    parameter int SYNC_LAT = 2,
    parameter int PH_W     = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             over_i,
    input  logic [PH_W-1:0]  raw_i,
    output logic [CNT_W-1:0] code_o,
    output logic             over_o
);
    localparam logic [PH_W-1:0] OFFSET = PH_W'(SYNC_LAT);

    logic [PH_W-1:0]  adj;
    logic [CNT_W-1:0] code_d;

    always_comb begin
        adj = (raw_i < OFFSET) ? '0 : raw_i - OFFSET;
        if (over_i) code_d = '1;
        else        code_d = adj[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            over_o <= 1'b0;
        end else if (load_i) begin
            code_o <= code_d;
            over_o <= over_i;
        end
    end
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
    import dslope_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int DISCH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_zero_i,
    output logic             discharge_o,
    output logic             integ_en_o,
    output logic             sel_ref_o,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o,
    output logic             overrange_o
);
    localparam int SYNC_LAT = 2;
    localparam int PH_W     = CNT_W + 1;
    localparam int DC_W     = (DISCH_CYC > 1) ? $clog2(DISCH_CYC) : 1;
    localparam logic [PH_W-1:0] PH1_LAST  = PH_W'((1 << CNT_W) - 1);
    localparam logic [PH_W-1:0] PH2_LIMIT = PH_W'((1 << CNT_W) - 1 + SYNC_LAT);
    localparam logic [DC_W-1:0] DC_LAST   = DC_W'(DISCH_CYC - 1);

    dsc_state_e      state_q, state_d;
    logic [DC_W-1:0] dcnt_q;
    logic [PH_W-1:0] ph_cnt;
    logic            cmp_s;
    logic            cnt_clr, cnt_en, load, over;
    logic            ph1_end, ph2_limit;

    dslope_sync #(.STAGES(SYNC_LAT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_zero_i),
        .q_o   (cmp_s)
    );

    dslope_counter #(.W(PH_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .en_i  (cnt_en),
        .cnt_o (ph_cnt)
    );

    dslope_result #(.CNT_W(CNT_W), .SYNC_LAT(SYNC_LAT), .PH_W(PH_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .over_i (over),
        .raw_i  (ph_cnt),
        .code_o (result_o),
        .over_o (overrange_o)
    );

    assign ph1_end   = (ph_cnt == PH1_LAST);
    assign ph2_limit = (ph_cnt == PH2_LIMIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Discharge length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dcnt_q <= '0;
        else if (state_q != ST_RESET) dcnt_q <= '0;
        else                         dcnt_q <= dcnt_q + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)              state_d = ST_RESET;
            ST_RESET:  if (dcnt_q == DC_LAST)    state_d = ST_INTEG1;
            ST_INTEG1: if (ph1_end)              state_d = ST_INTEG2;
            ST_INTEG2: if (cmp_s || ph2_limit)   state_d = ST_DONE;
            ST_DONE:                             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // Output and datapath control decode
    always_comb begin
        discharge_o = 1'b0;
        integ_en_o  = 1'b0;
        sel_ref_o   = 1'b0;
        valid_o     = 1'b0;
        cnt_clr     = 1'b0;
        cnt_en      = 1'b0;
        load        = 1'b0;
        over        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESET: begin
                discharge_o = 1'b1;
                cnt_clr     = 1'b1;
            end
            ST_INTEG1: begin
                integ_en_o = 1'b1;
                cnt_en     = 1'b1;
                cnt_clr    = ph1_end;
            end
            ST_INTEG2: begin
                integ_en_o = 1'b1;
                sel_ref_o  = 1'b1;
                cnt_en     = 1'b1;
                load       = cmp_s || ph2_limit;
                over       = !cmp_s && ph2_limit;
            end
            ST_DONE: valid_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dslope_ctrl_chk.sv
module dslope_ctrl_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             discharge_o,
    input logic             integ_en_o,
    input logic             sel_ref_o,
    input logic [CNT_W-1:0] result_o,
    input logic             valid_o,
    input logic             overrange_o
);
    a_r2_discharge_not_integ: assert property (@(posedge clk) disable iff (!rst_n)
        discharge_o |-> !integ_en_o);

    a_r2_integ_after_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ_en_o) |-> $past(discharge_o));

    a_r4_ref_needs_integ: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ref_o |-> integ_en_o);

    a_r4_ref_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref_o) |-> $past(integ_en_o));

    a_r6_over_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && overrange_o) |-> (result_o == {CNT_W{1'b1}}));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(result_o) && $stable(overrange_o)));

    a_r7_valid_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!integ_en_o && !discharge_o));
endmodule

bind dslope_ctrl dslope_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .discharge_o (discharge_o),
    .integ_en_o  (integ_en_o),
    .sel_ref_o   (sel_ref_o),
    .result_o    (result_o),
    .valid_o     (valid_o),
    .overrange_o (overrange_o)
);

// File: tb/dslope_ctrl_tb.sv
module dslope_ctrl_tb;
    localparam int CNT_W = 3;
    localparam int DCYC  = 4;
    localparam int FULL  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp;
    logic discharge, integ_en, sel_ref, valid, over;
    logic [CNT_W-1:0] result;

    int errors = 0;
    int checks = 0;
    int acc    = 0;
    int vin    = 0;
    int vref   = 8;

    always #5 clk = ~clk;

    dslope_ctrl #(.CNT_W(CNT_W), .DISCH_CYC(DCYC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cmp_zero_i  (cmp),
        .discharge_o (discharge),
        .integ_en_o  (integ_en),
        .sel_ref_o   (sel_ref),
        .result_o    (result),
        .valid_o     (valid),
        .overrange_o (over)
    );

    // Behavioural integrator and comparator
    always @(posedge clk) begin
        if (discharge)     acc <= 0;
        else if (integ_en) acc <= sel_ref ? acc - vref : acc + vin;
    end
    assign cmp = (acc <= 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk({discharge, integ_en, sel_ref, valid, over, result} == '0, "R1 outputs in reset",
            int'({discharge, integ_en, sel_ref, valid, over, result}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({discharge, integ_en, sel_ref, valid, over, result} == '0, "R1 outputs after reset",
            int'({discharge, integ_en, sel_ref, valid, over, result}), 0);
    endtask

    // One conversion; busy_at > 0 pulses start again in that cycle (R8)
    task automatic t_convert(input int in_v, input int ref_v, input int busy_at);
        int steps, exp_code, exp_lat, n, n_dis, n_in;
        bit exp_over, got;
        steps    = (in_v * (1 << CNT_W) + ref_v - 1) / ref_v;
        exp_over = (steps > FULL);
        exp_code = exp_over ? FULL : steps;
        if (exp_over)        exp_lat = DCYC + 18;
        else if (steps == 0) exp_lat = DCYC + 9;
        else                 exp_lat = DCYC + 11 + steps;

        @(negedge clk);
        vin = in_v; vref = ref_v; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0; n_dis = 0; n_in = 0; got = 1'b0;
        while (n < 200) begin
            if (discharge) n_dis++;
            if (integ_en && !sel_ref) n_in++;
            if (valid) begin
                got = 1'b1;
                break;
            end
            start = (busy_at > 0 && n == busy_at);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(got, "R7 valid seen", int'(got), 1);
        chk(n_dis == DCYC, "R2 discharge length", n_dis, DCYC);
        chk(n_in == (1 << CNT_W), "R3 input phase length", n_in, 1 << CNT_W);
        chk(result == CNT_W'(exp_code), "R5 code", int'(result), exp_code);
        chk(over == exp_over, "R6 overrange flag", int'(over), int'(exp_over));
        if (steps == 0)
            chk(n == exp_lat, "R9 zero-code latency", n, exp_lat);
        else
            chk(n == exp_lat, "R5 latency", n, exp_lat);
        @(negedge clk);
        chk(!valid, "R7 valid one cycle", int'(valid), 0);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (valid || discharge || integ_en) begin
                chk(1'b0, "R8 no extra conversion", 1, 0);
                break;
            end
        end
        chk(result == CNT_W'(exp_code) && over == exp_over, "R7 result held",
            int'(result), exp_code);
    endtask

    task automatic t_phase_switch;
        bit seen_switch, bad;
        @(negedge clk);
        vin = 2; vref = 8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen_switch = 1'b0; bad = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (sel_ref && !integ_en) bad = 1'b1;
            if (sel_ref) seen_switch = 1'b1;
            if (valid) break;
            @(negedge clk);
        end
        chk(seen_switch && !bad, "R4 reference phase with integrator on",
            int'({seen_switch, bad}), 2);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(1, 8, 0);   // R5 small code
        t_convert(3, 8, 0);   // R5 mid code
        t_convert(3, 5, 0);   // R5 non-power-of-two reference
        t_convert(2, 3, 0);   // R5 rounded-up quotient
        t_convert(0, 8, 0);   // R9 already at zero
        t_convert(7, 8, 0);   // R6 full-scale, no overrange
        t_convert(8, 8, 0);   // R6 overrange
        t_convert(20, 8, 0);  // R6 far overrange
        t_convert(4, 8, 3);   // R8 start during discharge
        t_convert(5, 8, 10);  // R8 start during input phase
        t_convert(2, 8, 15);  // R8 start during reference phase
        t_phase_switch();     // R4
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule